// File: doc/BRIEF.md
# Infrared Pulse Train Timer

This block drives an infrared output pin with a repeating two-phase waveform. The pin is held low for an active phase and then high for an inactive phase, and the pair repeats while the block is enabled. Each phase has its own 8-bit reload value and its own optional power-of-two prescaler. One down counter times whichever phase is running. When that counter underflows, it reloads from the value that belongs to the next phase.

Software programs the active-time value, the inactive-time value and a shared scale byte through a simple write port. A mode input selects whether the timing tick runs at the full clock rate or at half of it. Each phase end can raise its own one-cycle interrupt request, and a per-phase enable input gates that request. When the block is disabled, the pin is held high and the counters are frozen. Enabling the block again always starts a fresh active phase.

Top module: `ir_pulse_timer`

## Requirements
- R1: After reset, `ir_out` is 1, `low_irq` and `high_irq` are 0, and all three registers hold 0, so a first run with no writes gives a low phase and a high phase of one tick each.
- R2: In the first clock cycle after `enable` is seen high while idle, `ir_out` is 0. The counter is loaded from the low-time register, the prescaler is cleared, and no interrupt is raised at that start.
- R3: The low phase lasts (1 + low-time value) × low-phase scale ticks, for values from 0 to 255.
- R4: The high phase lasts (1 + high-time value) × high-phase scale ticks.
- R5: With `tick_div2` = 0, one tick occurs each clock cycle. With `tick_div2` = 1, one tick occurs every second clock cycle, so every phase lasts twice as many cycles.
- R6: In the scale byte, bit 7 enables the high-phase scale, bits 6:4 select it, bit 3 enables the low-phase scale, and bits 2:0 select it. A select value n gives a ratio of 2^(n+1), from 2 up to 256 ticks per count.
- R7: When a scale enable bit is 0, that phase runs at one count per tick and its select field has no effect.
- R8: A write with `wr_addr` 0 sets the low-time register, 1 sets the high-time register, 2 sets the scale byte, and 3 is ignored. A value written during a phase (including the scale) is used only from the next reload of that phase.
- R9: When the low phase ends, `low_irq` is 1 for exactly the first cycle of the high phase. When the high phase ends, `high_irq` is 1 for exactly the first cycle of the next low phase.
- R10: `low_irq` is raised only if `low_irq_en` was 1 in the cycle the phase ended, and `high_irq` only if `high_irq_en` was 1 in that cycle.
- R11: In the cycle after `enable` is seen low, `ir_out` is 1 and both interrupt outputs are 0. The counters then stay frozen, and re-enabling restarts with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the pulse train when 1 |
| tick_div2 | input | 1 | 0: tick every clock, 1: tick every second clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 low time, 1 high time, 2 scale, 3 unused |
| wr_data | input | 8 | Write data |
| low_irq_en | input | 1 | Gates the low-phase-end request |
| high_irq_en | input | 1 | Gates the high-phase-end request |
| ir_out | output | 1 | Infrared pin, low in the active phase |
| low_irq | output | 1 | One-cycle pulse at the end of a low phase |
| high_irq | output | 1 | One-cycle pulse at the end of a high phase |

## Verification
The bench builds the block with its default values: an 8-bit counter and a 3-bit scale select. This puts the full range in reach: reload values from 0 to 255, prescale ratios up to 1:256, and both tick modes. Directed cases cover the longest scaled phase with a zero reload and the longest unscaled phase. Random cases are constrained so that reload and ratio together keep each phase to about a thousand cycles.

// File: rtl/irt_pkg.sv
package irt_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    localparam logic [1:0] ADDR_LOW   = 2'd0;
    localparam logic [1:0] ADDR_HIGH  = 2'd1;
    localparam logic [1:0] ADDR_SCALE = 2'd2;
endpackage

// File: rtl/irt_tick_gen.sv
module irt_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic enable,
    input  logic div2,
    output logic tick
);
    typedef struct packed {
        logic half;
    } tick_state_t;

    tick_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.half = 1'b0;
        end else if (enable && div2) begin
            s_d.half = ~s_q.half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = enable && (!div2 || s_q.half);
endmodule

// File: rtl/irt_prescaler.sv
module irt_prescaler #(
    parameter int SEL_W = 3,
    localparam int PRE_W = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic             scale_en,
    input  logic [SEL_W-1:0] scale_sel,
    output logic             step
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [SEL_W:0]   shift_amt;
    logic [PRE_W:0]   limit_w;
    logic [PRE_W-1:0] limit;

    always_comb begin
        shift_amt = {1'b0, scale_sel} + (SEL_W+1)'(1);
        limit_w   = ((PRE_W+1)'(1) << shift_amt) - (PRE_W+1)'(1);
        limit     = scale_en ? limit_w[PRE_W-1:0] : '0;
        step      = tick && (s_q.cnt == limit);

        s_d = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = step ? '0 : s_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irt_phase_ctl.sv
module irt_phase_ctl
    import irt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             step,
    input  logic [CNT_W-1:0] low_val,
    input  logic [CNT_W-1:0] high_val,
    input  logic             low_sc_en,
    input  logic [SEL_W-1:0] low_sc_sel,
    input  logic             high_sc_en,
    input  logic [SEL_W-1:0] high_sc_sel,
    input  logic             low_irq_en,
    input  logic             high_irq_en,
    output logic             restart,
    output logic             cur_sc_en,
    output logic [SEL_W-1:0] cur_sc_sel,
    output logic             ir_out,
    output logic             low_irq,
    output logic             high_irq
);
    typedef struct packed {
        logic             running;
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             sc_en;
        logic [SEL_W-1:0] sc_sel;
        logic             low_irq;
        logic             high_irq;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    always_comb begin
        restart      = enable && !s_q.running;
        s_d          = s_q;
        s_d.low_irq  = 1'b0;
        s_d.high_irq = 1'b0;
        if (!enable) begin
            s_d.running = 1'b0;
        end else if (!s_q.running) begin
            s_d.running = 1'b1;
            s_d.phase   = PH_LOW;
            s_d.cnt     = low_val;
            s_d.sc_en   = low_sc_en;
            s_d.sc_sel  = low_sc_sel;
        end else if (step) begin
            if (s_q.cnt == '0) begin
                if (s_q.phase == PH_LOW) begin
                    s_d.phase   = PH_HIGH;
                    s_d.cnt     = high_val;
                    s_d.sc_en   = high_sc_en;
                    s_d.sc_sel  = high_sc_sel;
                    s_d.low_irq = low_irq_en;
                end else begin
                    s_d.phase    = PH_LOW;
                    s_d.cnt      = low_val;
                    s_d.sc_en    = low_sc_en;
                    s_d.sc_sel   = low_sc_sel;
                    s_d.high_irq = high_irq_en;
                end
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_LOW;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_sc_en  = s_q.sc_en;
    assign cur_sc_sel = s_q.sc_sel;
    assign ir_out     = !(s_q.running && s_q.phase == PH_LOW);
    assign low_irq    = s_q.low_irq;
    assign high_irq   = s_q.high_irq;
endmodule

// File: rtl/ir_pulse_timer.sv
module ir_pulse_timer
    import irt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3,
    localparam int SCALE_W = 2 * (SEL_W + 1),
    localparam int DAT_W = (CNT_W > SCALE_W) ? CNT_W : SCALE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick_div2,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             low_irq_en,
    input  logic             high_irq_en,
    output logic             ir_out,
    output logic             low_irq,
    output logic             high_irq
);
    typedef struct packed {
        logic [CNT_W-1:0]   low_time;
        logic [CNT_W-1:0]   high_time;
        logic [SCALE_W-1:0] scale;
    } reg_state_t;

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_LOW:   r_d.low_time  = wr_data[CNT_W-1:0];
                ADDR_HIGH:  r_d.high_time = wr_data[CNT_W-1:0];
                ADDR_SCALE: r_d.scale     = wr_data[SCALE_W-1:0];
                default:    r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    logic             high_sc_en, low_sc_en;
    logic [SEL_W-1:0] high_sc_sel, low_sc_sel;

    assign high_sc_en  = r_q.scale[SCALE_W-1];
    assign high_sc_sel = r_q.scale[SCALE_W-2:SEL_W+1];
    assign low_sc_en   = r_q.scale[SEL_W];
    assign low_sc_sel  = r_q.scale[SEL_W-1:0];

    logic             restart, tick, step, cur_sc_en;
    logic [SEL_W-1:0] cur_sc_sel;

    irt_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .enable  (enable),
        .div2    (tick_div2),
        .tick    (tick)
    );

    irt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .tick      (tick),
        .scale_en  (cur_sc_en),
        .scale_sel (cur_sc_sel),
        .step      (step)
    );

    irt_phase_ctl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .step        (step),
        .low_val     (r_q.low_time),
        .high_val    (r_q.high_time),
        .low_sc_en   (low_sc_en),
        .low_sc_sel  (low_sc_sel),
        .high_sc_en  (high_sc_en),
        .high_sc_sel (high_sc_sel),
        .low_irq_en  (low_irq_en),
        .high_irq_en (high_irq_en),
        .restart     (restart),
        .cur_sc_en   (cur_sc_en),
        .cur_sc_sel  (cur_sc_sel),
        .ir_out      (ir_out),
        .low_irq     (low_irq),
        .high_irq    (high_irq)
    );
endmodule

// File: rtl/irt_checker.sv
module irt_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic low_irq_en,
    input logic high_irq_en,
    input logic ir_out,
    input logic low_irq,
    input logic high_irq
);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !$past(enable)) |=> !ir_out);

    assert_low_irq_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        low_irq |-> $rose(ir_out));

    assert_high_irq_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        high_irq |-> $fell(ir_out));

    assert_low_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        low_irq |=> !low_irq);

    assert_high_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        high_irq |=> !high_irq);

    assert_irq_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({low_irq, high_irq}) <= 1);

    assert_low_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        low_irq |-> $past(low_irq_en));

    assert_high_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        high_irq |-> $past(high_irq_en));

    assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ir_out);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!low_irq && !high_irq));
endmodule

bind ir_pulse_timer irt_checker u_irt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .low_irq_en  (low_irq_en),
    .high_irq_en (high_irq_en),
    .ir_out      (ir_out),
    .low_irq     (low_irq),
    .high_irq    (high_irq)
);

// File: tb/ir_pulse_timer_bench.sv
module ir_pulse_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       tick_div2 = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       low_irq_en = 1'b0;
    logic       high_irq_en = 1'b0;
    logic       ir_out, low_irq, high_irq;

    int tests = 0;
    int fails = 0;
    localparam int CAP = 20000;

    always #4 clk = ~clk;

    ir_pulse_timer u_ir_pulse_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_div2(tick_div2),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .low_irq_en(low_irq_en), .high_irq_en(high_irq_en),
        .ir_out(ir_out), .low_irq(low_irq), .high_irq(high_irq)
    );

    function automatic int ratio(input int en, input int sel);
        return en != 0 ? (1 << (sel + 1)) : 1;
    endfunction

    function automatic int exp_len(input int n, input int en, input int sel, input int div2);
        return (n + 1) * ratio(en, sel) * (div2 != 0 ? 2 : 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_phase(input logic lvl, output int len, output int f_lo,
                               output int f_hi, output int extra);
        len = 0; extra = 0;
        f_lo = int'(low_irq); f_hi = int'(high_irq);
        while (ir_out == lvl && len < CAP) begin
            len++;
            if (len > 1 && (low_irq || high_irq)) extra++;
            @(negedge clk);
        end
    endtask

    task automatic run_case(input string tag, input int div2, input int ln, input int hn,
                            input int lsc_en, input int lsel, input int hsc_en, input int hsel,
                            input int lie, input int hie);
        int len, f_lo, f_hi, extra;
        write_reg(2'd0, 8'(ln));
        write_reg(2'd1, 8'(hn));
        write_reg(2'd2, {1'(hsc_en), 3'(hsel), 1'(lsc_en), 3'(lsel)});
        tick_div2 = 1'(div2); low_irq_en = 1'(lie); high_irq_en = 1'(hie);
        enable = 1'b1;
        @(negedge clk);
        check({tag, " R2 start low"}, int'(ir_out), 0);
        count_phase(1'b0, len, f_lo, f_hi, extra);
        check({tag, " R3 R5 low length"}, len, exp_len(ln, lsc_en, lsel, div2));
        check({tag, " R2 no irq in first low"}, f_hi + f_lo + extra, 0);
        count_phase(1'b1, len, f_lo, f_hi, extra);
        check({tag, " R4 R5 high length"}, len, exp_len(hn, hsc_en, hsel, div2));
        check({tag, " R9 R10 low_irq at high start"}, f_lo * 2 + f_hi, lie * 2);
        check({tag, " R9 no stray irq in high"}, extra, 0);
        check({tag, " R9 R10 high_irq at low start"},
              int'(high_irq) * 2 + int'(low_irq), hie * 2);
        enable = 1'b0;
        @(negedge clk);
        check({tag, " R11 idle state"},
              int'(ir_out) * 4 + int'(low_irq) * 2 + int'(high_irq), 4);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int len, f_lo, f_hi, extra, bad;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", int'(ir_out) * 4 + int'(low_irq) * 2 + int'(high_irq), 4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset outputs", int'(ir_out) * 4 + int'(low_irq) * 2 + int'(high_irq), 4);

        // R1: registers at zero give one-tick phases
        enable = 1'b1; low_irq_en = 1'b1; high_irq_en = 1'b1;
        @(negedge clk);
        count_phase(1'b0, len, f_lo, f_hi, extra);
        check("R1 zero low length", len, 1);
        count_phase(1'b1, len, f_lo, f_hi, extra);
        check("R1 zero high length", len, 1);
        enable = 1'b0;
        repeat (2) @(negedge clk);

        // Directed corners
        run_case("div2", 1, 3, 5, 0, 0, 0, 0, 1, 1);                 // R5
        run_case("max-scale", 0, 0, 2, 1, 7, 1, 0, 1, 0);            // R6 1:256 and 1:2
        run_case("max-scale-div2", 1, 0, 0, 1, 7, 0, 0, 0, 1);       // R6 R5
        run_case("sel-ignored", 0, 4, 3, 0, 7, 0, 7, 1, 1);          // R7
        run_case("max-count", 0, 255, 255, 0, 0, 0, 0, 0, 0);        // R3 R4 R10
        run_case("mid-sel", 0, 5, 6, 1, 2, 1, 4, 1, 0);              // R6

        // R8: writes during a phase apply only at the next reload
        write_reg(2'd0, 8'd9);
        write_reg(2'd1, 8'd4);
        write_reg(2'd2, 8'h00);
        tick_div2 = 1'b0; low_irq_en = 1'b1; high_irq_en = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        write_reg(2'd0, 8'd2);
        write_reg(2'd3, 8'hFF);
        write_reg(2'd2, 8'h08);
        count_phase(1'b0, len, f_lo, f_hi, extra);
        check("R8 current low unchanged", len + 3, 10);
        count_phase(1'b1, len, f_lo, f_hi, extra);
        check("R8 address 3 ignored, high unchanged", len, 5);
        count_phase(1'b0, len, f_lo, f_hi, extra);
        check("R8 new low after reload", len, 6);
        enable = 1'b0;
        @(negedge clk);

        // R11: freeze while disabled, then restart with a full low phase
        write_reg(2'd0, 8'd50);
        write_reg(2'd1, 8'd3);
        write_reg(2'd2, 8'h00);
        enable = 1'b1;
        repeat (11) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            if (!ir_out || low_irq || high_irq) bad++;
            @(negedge clk);
        end
        check("R11 held high and quiet while disabled", bad, 0);
        enable = 1'b1;
        @(negedge clk);
        count_phase(1'b0, len, f_lo, f_hi, extra);
        check("R11 restart gives full low phase", len, 51);
        enable = 1'b0;
        @(negedge clk);

        // Constrained random cases
        for (int it = 0; it < 25; it++) begin
            int d2, le, ls, he, hs, lmax, hmax, ln, hn;
            d2 = int'($urandom % 2);
            le = int'($urandom % 2); ls = int'($urandom % 8);
            he = int'($urandom % 2); hs = int'($urandom % 8);
            lmax = 1024 / (ratio(le, ls) * (d2 + 1));
            hmax = 1024 / (ratio(he, hs) * (d2 + 1));
            if (lmax > 256) lmax = 256;
            if (hmax > 256) hmax = 256;
            ln = int'($urandom % lmax);
            hn = int'($urandom % hmax);
            run_case($sformatf("rand%0d", it), d2, ln, hn, le, ls, he, hs,
                     int'($urandom % 2), int'($urandom % 2));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule